// File: doc/BRIEF.md
# Three-Level PWM Gate-Drive Sequencer

This block is the clocked control core that decides when the high-side and low-side switch gates of a synchronous buck stage may be driven. It accepts a decoded PWM command that can be low, mid or high. It also takes an enable, a force-off input from outside fault supervision, and four comparator flags: switch node low, inductor zero cross, high gate sensed off and low gate sensed off. From these it produces the two gate-enable outputs, `drvh` and `drvl`.

Dead time is adaptive. Before a gate turns on, the opposite gate must be reported off, and that report must then hold for a programmable number of clock cycles. The mid command selects diode emulation. The low side is switched on, a blanking window masks the zero-cross flag, and the first zero cross after the window turns the low side off, leaving both gates off. Every low-going wait also runs a timeout, so the low side turns on even when the switch node never reports low. All intervals are parameters counted in clock cycles.

Top module: `gate_seq`

## Requirements
- R1: After reset both outputs are 0, and `drvh` and `drvl` are never 1 in the same cycle.
- R2: Command encoding is 00 low, 01 mid, 10 high and 11 mid. When command 10 is sampled at a clock edge, the sequencer enters a high-going wait. `drvh` turns on after `lg_off` has been 1 at DEAD_CYC+1 consecutive clock edges within that wait. `drvl` is 0 throughout.
- R3: When command 00 is sampled, `drvh` goes to 0 right after that edge. `drvl` turns on after the low qualifier has been 1 at DEAD_CYC+1 consecutive edges of the low-going wait. The low qualifier is `hg_off` AND `sw_low` when SW_QUAL=1, and `hg_off` alone otherwise.
- R4: If the sensed-off qualifier of a wait drops to 0 at an edge, the dead-time count restarts from zero.
- R5: A low-going wait that has lasted TMO_CYC+1 edges turns `drvl` on even if the qualifier never came true.
- R6: Command mid (01) turns `drvh` off at once. It then brings `drvl` on, either through the low-going wait or directly when `drvl` is already on. `zero_cross` is ignored during the first BLANK_CYC+1 edges of that diode-emulation on-phase.
- R7: After the blanking window, `zero_cross` = 1 at an edge turns `drvl` off. Both gates then stay off until the command becomes low or high.
- R8: A command change during any wait restarts the sequence toward the new target, with fresh dead-time and timeout counts. No previously targeted gate is asserted.
- R9: `en` = 0 or `force_off` = 1 forces both outputs to 0 in the same cycle and returns the sequencer to idle. Once released, the sequence starts over from idle.
- R10: Command 11 behaves exactly like command 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enable; 0 forces both gates off |
| force_off | input | 1 | Fault force-off; 1 forces both gates off |
| pwm_cmd | input | 2 | Decoded PWM level: 00 low, 01 mid, 10 high, 11 mid |
| sw_low | input | 1 | Switch node is sensed low |
| zero_cross | input | 1 | Inductor current has reached zero |
| hg_off | input | 1 | High-side gate is sensed off |
| lg_off | input | 1 | Low-side gate is sensed off |
| drvh | output | 1 | High-side gate enable |
| drvl | output | 1 | Low-side gate enable |

## Verification
The bench aims at the points where a sequencer most often goes wrong. It asserts zero cross inside the blanking window, where a design that fails to blank would drop the low side early. It removes the sensed-off flag partway through a dead-time count, where a design that does not restart the count would switch on too soon. It holds the switch node high so that only the timeout can turn the low side on; a missing timeout would leave both gates off indefinitely. It reverses the command in the middle of a wait, where a design holding stale state would drive the wrong gate. Finally, it pulses enable and force-off and checks that both outputs drop in the same cycle rather than one edge later.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;

   typedef enum logic [1:0] {
      GOAL_LOW  = 2'd0,
      GOAL_MID  = 2'd1,
      GOAL_HIGH = 2'd2
   } goal_e;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_WAIT_H  = 3'd1,
      ST_HIGH    = 3'd2,
      ST_WAIT_L  = 3'd3,
      ST_WAIT_DE = 3'd4,
      ST_LOW     = 3'd5,
      ST_DE_ON   = 3'd6,
      ST_DE_OFF  = 3'd7
   } seq_st_e;

endpackage

// File: rtl/gs_cmd_decode.sv
module gs_cmd_decode
   import gate_seq_pkg::*;
(
   input  logic [1:0] code,
   output goal_e      goal
);
   // R10: both codes with bit 0 set select the mid level
   always_comb begin
      case (code)
         2'b00:   goal = GOAL_LOW;
         2'b10:   goal = GOAL_HIGH;
         default: goal = GOAL_MID;
      endcase
   end
endmodule

// File: rtl/gs_step_timer.sv
module gs_step_timer #(
   parameter int LIMIT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic done
);
   localparam int W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
   localparam logic [W-1:0] LIM = W'(LIMIT);

   logic [W-1:0] cnt_q;

   assign done = (cnt_q == LIM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (clr)          cnt_q <= '0;
      else if (inc && !done) cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/gs_sequencer.sv
module gs_sequencer
   import gate_seq_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    run,
   input  goal_e   goal,
   input  logic    dead_qual,
   input  logic    dead_done,
   input  logic    tmo_done,
   input  logic    blank_done,
   input  logic    zero_cross,
   output seq_st_e st_q,
   output logic    st_chg
);
   seq_st_e st_d;
   logic    low_go;

   assign low_go = (dead_qual && dead_done) || tmo_done;
   assign st_chg = (st_d != st_q);

   always_comb begin
      st_d = st_q;
      if (!run) begin
         st_d = ST_IDLE;
      end else begin
         case (st_q)
            ST_IDLE: begin
               case (goal)
                  GOAL_HIGH: st_d = ST_WAIT_H;
                  GOAL_LOW:  st_d = ST_WAIT_L;
                  default:   st_d = ST_WAIT_DE;
               endcase
            end
            ST_WAIT_H: begin
               if (goal == GOAL_LOW)           st_d = ST_WAIT_L;
               else if (goal == GOAL_MID)      st_d = ST_WAIT_DE;
               else if (dead_qual && dead_done) st_d = ST_HIGH;
            end
            ST_HIGH: begin
               if (goal == GOAL_LOW)      st_d = ST_WAIT_L;
               else if (goal == GOAL_MID) st_d = ST_WAIT_DE;
            end
            ST_WAIT_L: begin
               if (goal == GOAL_HIGH)     st_d = ST_WAIT_H;
               else if (goal == GOAL_MID) st_d = ST_WAIT_DE;
               else if (low_go)           st_d = ST_LOW;
            end
            ST_WAIT_DE: begin
               if (goal == GOAL_HIGH)     st_d = ST_WAIT_H;
               else if (goal == GOAL_LOW) st_d = ST_WAIT_L;
               else if (low_go)           st_d = ST_DE_ON;
            end
            ST_LOW: begin
               if (goal == GOAL_HIGH)     st_d = ST_WAIT_H;
               else if (goal == GOAL_MID) st_d = ST_DE_ON;
            end
            ST_DE_ON: begin
               if (goal == GOAL_HIGH)              st_d = ST_WAIT_H;
               else if (goal == GOAL_LOW)          st_d = ST_LOW;
               else if (blank_done && zero_cross)  st_d = ST_DE_OFF;
            end
            default: begin
               if (goal == GOAL_HIGH)     st_d = ST_WAIT_H;
               else if (goal == GOAL_LOW) st_d = ST_WAIT_L;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end
endmodule

// File: rtl/gate_seq.sv
module gate_seq
   import gate_seq_pkg::*;
#(
   parameter int DEAD_CYC  = 2,
   parameter int BLANK_CYC = 25,
   parameter int TMO_CYC   = 100,
   parameter bit SW_QUAL   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       force_off,
   input  logic [1:0] pwm_cmd,
   input  logic       sw_low,
   input  logic       zero_cross,
   input  logic       hg_off,
   input  logic       lg_off,
   output logic       drvh,
   output logic       drvl
);
   if (DEAD_CYC < 0) begin : g_bad_dead
      $error("DEAD_CYC must not be negative");
   end
   if (TMO_CYC <= DEAD_CYC) begin : g_bad_tmo
      $error("TMO_CYC must exceed DEAD_CYC");
   end
   if (BLANK_CYC < 1) begin : g_bad_blank
      $error("BLANK_CYC must be at least 1");
   end

   goal_e   goal;
   seq_st_e st_q;
   logic    st_chg, run, low_ok, in_wh, in_wl, in_de;
   logic    dead_qual, dead_done, tmo_done, blank_done;

   assign run = en && !force_off;

   if (SW_QUAL) begin : g_qual_sw
      assign low_ok = hg_off && sw_low;
   end else begin : g_qual_gate
      assign low_ok = hg_off;
   end

   assign in_wh     = (st_q == ST_WAIT_H);
   assign in_wl     = (st_q == ST_WAIT_L) || (st_q == ST_WAIT_DE);
   assign in_de     = (st_q == ST_DE_ON);
   assign dead_qual = (in_wh && lg_off) || (in_wl && low_ok);

   gs_cmd_decode u_dec (.code(pwm_cmd), .goal(goal));

   gs_step_timer #(.LIMIT(DEAD_CYC)) u_dead (
      .clk(clk), .rst_n(rst_n), .clr(st_chg || !dead_qual),
      .inc(dead_qual), .done(dead_done));

   gs_step_timer #(.LIMIT(TMO_CYC)) u_tmo (
      .clk(clk), .rst_n(rst_n), .clr(st_chg),
      .inc(in_wl), .done(tmo_done));

   gs_step_timer #(.LIMIT(BLANK_CYC)) u_blank (
      .clk(clk), .rst_n(rst_n), .clr(st_chg),
      .inc(in_de), .done(blank_done));

   gs_sequencer u_seq (
      .clk(clk), .rst_n(rst_n), .run(run), .goal(goal),
      .dead_qual(dead_qual), .dead_done(dead_done), .tmo_done(tmo_done),
      .blank_done(blank_done), .zero_cross(zero_cross),
      .st_q(st_q), .st_chg(st_chg));

   // R9: gating by run takes effect in the same cycle
   assign drvh = run && (st_q == ST_HIGH);
   assign drvl = run && ((st_q == ST_LOW) || (st_q == ST_DE_ON));
endmodule

// File: rtl/gate_seq_chk.sv
module gate_seq_chk #(
   parameter int BLANK_CYC = 25
) (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic force_off,
   input logic pwm_mid,
   input logic lg_off,
   input logic drvh,
   input logic drvl
);
   localparam int RW = $clog2(BLANK_CYC + 2);
   localparam logic [RW-1:0] RMAX = RW'(BLANK_CYC + 1);

   logic [RW-1:0] on_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               on_run_q <= '0;
      else if (!drvl)           on_run_q <= '0;
      else if (on_run_q != RMAX) on_run_q <= on_run_q + 1'b1;
   end

   // R1
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(drvh && drvl));

   // R9
   off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en || force_off) |-> (!drvh && !drvl));

   // R2
   high_after_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drvh) |-> ($past(lg_off) && !$past(drvl)));

   // R3
   low_after_high_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drvl) |-> !$past(drvh));

   // R6
   blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(drvl) && en && !force_off && $past(pwm_mid)) |-> (on_run_q >= RMAX));
endmodule

bind gate_seq gate_seq_chk #(.BLANK_CYC(BLANK_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .force_off(force_off),
   .pwm_mid(pwm_cmd[0]), .lg_off(lg_off), .drvh(drvh), .drvl(drvl));

// File: tb/gate_seq_tb_top.sv
module gate_seq_tb_top;
   localparam int DEAD  = 2;
   localparam int BLANK = 25;
   localparam int TMO   = 100;

   localparam int M_IDLE = 0, M_WH = 1, M_HI = 2, M_WL = 3,
                  M_WD = 4, M_LO = 5, M_DON = 6, M_DOFF = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, force_off = 1'b0;
   logic [1:0] pwm_cmd = 2'b00;
   logic sw_low = 1'b1, zero_cross = 1'b0, hg_off = 1'b1, lg_off = 1'b1;
   logic drvh, drvl;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;
   string tag = "R1";

   int m_st = M_IDLE;
   int m_dead = 0, m_tmo = 0, m_blank = 0;

   always #5 clk = ~clk;

   gate_seq #(.DEAD_CYC(DEAD), .BLANK_CYC(BLANK), .TMO_CYC(TMO), .SW_QUAL(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .force_off(force_off),
      .pwm_cmd(pwm_cmd), .sw_low(sw_low), .zero_cross(zero_cross),
      .hg_off(hg_off), .lg_off(lg_off), .drvh(drvh), .drvl(drvl));

   // reference model: level 0 low, 1 mid, 2 high
   function automatic int level(input logic [1:0] c);
      if (c == 2'b10) return 2;
      if (c == 2'b00) return 0;
      return 1;
   endfunction

   function automatic int next_state();
      int lv = level(pwm_cmd);
      bit lowq = hg_off && sw_low;
      bit lowgo = (lowq && m_dead == DEAD) || (m_tmo == TMO);
      if (!en || force_off) return M_IDLE;
      case (m_st)
         M_IDLE: return (lv == 2) ? M_WH : (lv == 0) ? M_WL : M_WD;
         M_WH: begin
            if (lv == 0) return M_WL;
            if (lv == 1) return M_WD;
            if (lg_off && m_dead == DEAD) return M_HI;
            return M_WH;
         end
         M_HI: return (lv == 0) ? M_WL : (lv == 1) ? M_WD : M_HI;
         M_WL: begin
            if (lv == 2) return M_WH;
            if (lv == 1) return M_WD;
            return lowgo ? M_LO : M_WL;
         end
         M_WD: begin
            if (lv == 2) return M_WH;
            if (lv == 0) return M_WL;
            return lowgo ? M_DON : M_WD;
         end
         M_LO: return (lv == 2) ? M_WH : (lv == 1) ? M_DON : M_LO;
         M_DON: begin
            if (lv == 2) return M_WH;
            if (lv == 0) return M_LO;
            if (m_blank == BLANK && zero_cross) return M_DOFF;
            return M_DON;
         end
         default: return (lv == 2) ? M_WH : (lv == 0) ? M_WL : M_DOFF;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st <= M_IDLE; m_dead <= 0; m_tmo <= 0; m_blank <= 0;
      end else begin
         int nx;
         bit q;
         nx = next_state();
         if (nx != m_st) begin
            m_dead <= 0; m_tmo <= 0; m_blank <= 0;
         end else begin
            q = (m_st == M_WH) ? lg_off :
                (m_st == M_WL || m_st == M_WD) ? (hg_off && sw_low) : 1'b0;
            if (!q) m_dead <= 0;
            else if (m_dead != DEAD) m_dead <= m_dead + 1;
            if ((m_st == M_WL || m_st == M_WD) && m_tmo != TMO) m_tmo <= m_tmo + 1;
            if (m_st == M_DON && m_blank != BLANK) m_blank <= m_blank + 1;
         end
         m_st <= nx;
      end
   end

   task automatic compare();
      bit run = en && !force_off;
      bit eh = run && (m_st == M_HI);
      bit el = run && (m_st == M_LO || m_st == M_DON);
      vectors++;
      if (drvh !== eh || drvl !== el) begin
         miscompares++;
         $display("FAIL %s: drvh=%0b drvl=%0b expected drvh=%0b drvl=%0b at %0t",
                  tag, drvh, drvl, eh, el, $time);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1 compare();
      end
   endtask

   task automatic setcmd(input logic [1:0] c);
      @(negedge clk);
      pwm_cmd = c;
   endtask

   initial begin
      // R1: reset state, then idle with enable low
      tag = "R1";
      repeat (3) @(negedge clk);
      #1 compare();
      rst_n = 1'b1;
      tick(3);
      @(negedge clk); en = 1'b1;
      // R3: low command with qualifiers true
      tag = "R3";
      tick(8);
      // R2: high command
      tag = "R2"; setcmd(2'b10); tick(8);
      // R4: low qualifier bouncing restarts dead count
      tag = "R4";
      @(negedge clk); hg_off = 1'b0; pwm_cmd = 2'b00; tick(3);
      @(negedge clk); hg_off = 1'b1; tick(1);
      @(negedge clk); hg_off = 1'b0; tick(1);
      @(negedge clk); hg_off = 1'b1; tick(6);
      // R4: lg_off bouncing on the high side
      @(negedge clk); lg_off = 1'b0; pwm_cmd = 2'b10; tick(4);
      @(negedge clk); lg_off = 1'b1; tick(1);
      @(negedge clk); lg_off = 1'b0; tick(1);
      @(negedge clk); lg_off = 1'b1; tick(6);
      // R5: switch node never low, timeout turns low side on
      tag = "R5";
      @(negedge clk); sw_low = 1'b0; pwm_cmd = 2'b00; tick(TMO + 8);
      @(negedge clk); sw_low = 1'b1;
      // R6: mid from high, zero cross held during blanking
      tag = "R6"; setcmd(2'b10); tick(8);
      @(negedge clk); pwm_cmd = 2'b01; zero_cross = 1'b1; tick(BLANK);
      // R7: after blanking zero cross turns low side off
      tag = "R7"; tick(12);
      setcmd(2'b00); tick(8);
      // R6: mid entered with low side already on
      tag = "R6";
      @(negedge clk); zero_cross = 1'b0; pwm_cmd = 2'b01; tick(BLANK + 6);
      tag = "R7";
      @(negedge clk); zero_cross = 1'b1; tick(5);
      @(negedge clk); zero_cross = 1'b0;
      // R8: command reversals inside waits
      tag = "R8";
      setcmd(2'b10); tick(8);
      setcmd(2'b00); tick(2);
      setcmd(2'b10); tick(1);
      setcmd(2'b01); tick(2);
      setcmd(2'b00); tick(1);
      setcmd(2'b10); tick(8);
      // R9: enable low and force-off while gates are on
      tag = "R9";
      @(negedge clk); en = 1'b0; tick(3);
      @(negedge clk); en = 1'b1; tick(8);
      @(negedge clk); force_off = 1'b1; tick(2);
      @(negedge clk); force_off = 1'b0; tick(8);
      setcmd(2'b00); tick(8);
      @(negedge clk); en = 1'b0; tick(1);
      @(negedge clk); en = 1'b1; tick(8);
      // R10: code 11 acts as mid
      tag = "R10";
      setcmd(2'b10); tick(8);
      setcmd(2'b11); tick(10);
      @(negedge clk); zero_cross = 1'b1; tick(BLANK + 8);
      @(negedge clk); zero_cross = 1'b0; tick(2);

      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         finished = 1'b1;
         miscompares++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule